// File: doc/BRIEF.md
# Frame Sync Word Correlator with Line Timing

This block finds frame boundaries in a recovered serial bit stream. It takes one data bit per bit-clock enable, moves it into a 64-bit sliding window, and counts how many window positions agree with a fixed frame synchronization word. When enough positions agree, the block produces a one-cycle frame pulse. A small number of bit errors is tolerated, so the pulse still appears on a noisy channel. After each pulse, further matches are ignored for a set number of bits. This keeps one sync word from producing more than one pulse.

Line timing is not taken from the stream. It is counted from the frame pulse. A bit counter wraps once per line and produces a line pulse at each wrap. A line number starts at 1 on the frame pulse and wraps after the last line of the frame. The stream can run at full rate or at half rate. At half rate a line holds half as many bits, because the line period stays the same. All state is frozen while the bit enable is low.

Top module: `fsync_correlator`

## Requirements
- R1: After reset, both pulses are low and the line number is 0. The line number stays 0, and no line pulse occurs, until the first frame pulse.
- R2: An exact copy of the sync word produces a frame pulse. The word is sent most significant bit first. The pulse is high in the clock cycle after the edge that accepts the word's last bit.
- R3: A window that differs from the word in at most WIN-THRESH positions (3 by default) still produces a frame pulse. One more differing position produces none.
- R4: After a frame pulse, matches are ignored for the next HOLDOFF enabled bits. A match completed on enabled bit HOLDOFF+1 or later produces a pulse again.
- R5: At full rate (`half_rate_i`=0), a line pulse follows every LINE_BITS enabled bits after the frame bit. A frame pulse restarts this count, and a frame pulse never coincides with a line pulse.
- R6: At half rate (`half_rate_i`=1), a line lasts LINE_BITS/2 enabled bits.
- R7: The frame pulse sets the line number to 1. Each line pulse increments it. After LINES it wraps to 1.
- R8: While `bit_en_i` is low, no pulse is produced and the line number does not change. Window, holdoff and counters are not advanced.
- R9: Each frame pulse and each line pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_i | input | 1 | Recovered data bit |
| bit_en_i | input | 1 | Bit-clock enable; one bit is accepted per high cycle |
| half_rate_i | input | 1 | 0: full bit rate, 1: half bit rate (line length halved) |
| frame_pulse_o | output | 1 | One-cycle frame reset pulse |
| line_pulse_o | output | 1 | One-cycle pulse at each line boundary |
| line_num_o | output | $clog2(LINES+1) | Current line number, 0 before the first frame |

## Verification
A corrupted window or threshold comparison shows up as a missing or extra frame pulse. It appears one clock after the enabled bit that completes or breaks the match. A wrong holdoff count shows up only when a second sync word arrives near the HOLDOFF boundary, so both sides of that boundary are driven. A bit counter that drifts makes the next line pulse early or late within one line of bits, and the line number then goes wrong from that pulse onward. A cycle-by-cycle model of all three outputs therefore catches such faults within one line.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  // Default 64-bit frame synchronization word, first transmitted bit at MSB.
  localparam logic [63:0] FSC_DEFAULT_WORD = 64'hB5E3_1A7C_0F92_D64B;

  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;

endpackage

// File: rtl/fsc_window.sv
module fsc_window #(
  parameter int              WIN    = 64,
  parameter int              THRESH = 61,
  parameter logic [WIN-1:0]  WORD   = fsc_pkg::FSC_DEFAULT_WORD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  output logic hit_o
);

  localparam int CNT_W = $clog2(WIN + 1);

  logic [WIN-1:0]   win_q;
  logic [WIN-1:0]   win_d;
  logic [CNT_W-1:0] agree;

  // Next window (newest bit at LSB) and its agreement count with the word.
  always_comb begin
    win_d = {win_q[WIN-2:0], bit_i};
    agree = '0;
    for (int i = 0; i < WIN; i++) begin
      agree = agree + CNT_W'(~(win_d[i] ^ WORD[i]));
    end
    hit_o = en_i && (agree >= CNT_W'(THRESH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (en_i) begin
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/fsc_frame_det.sv
module fsc_frame_det #(
  parameter int HOLDOFF = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hit_i,
  output logic fire_o,
  output logic frame_pulse_o
);

  localparam int HOLD_W = $clog2(HOLDOFF + 1);

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_d;
  logic              pulse_d;

  always_comb begin
    fire_o  = hit_i && (hold_q == '0);
    pulse_d = fire_o;
    hold_d  = hold_q;
    if (fire_o) begin
      hold_d = HOLD_W'(HOLDOFF);
    end else if (en_i && (hold_q != '0)) begin
      hold_d = hold_q - HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q        <= '0;
      frame_pulse_o <= 1'b0;
    end else begin
      hold_q        <= hold_d;
      frame_pulse_o <= pulse_d;
    end
  end

  // R9
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse_o |=> !frame_pulse_o);

  // R4
  holdoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && hold_q != '0) |=> !frame_pulse_o);

endmodule

// File: rtl/fsc_line_timer.sv
module fsc_line_timer #(
  parameter int LINE_BITS = 1296,
  parameter int LINES     = 625
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en_i,
  input  logic                         fire_i,
  input  logic                         half_i,
  output logic                         line_pulse_o,
  output logic [$clog2(LINES+1)-1:0]   line_num_o
);

  localparam int BCNT_W = $clog2(LINE_BITS);
  localparam int LNUM_W = $clog2(LINES + 1);
  localparam logic [BCNT_W:0] FULL_LIM = (BCNT_W+1)'(LINE_BITS);
  localparam logic [BCNT_W:0] HALF_LIM = (BCNT_W+1)'(LINE_BITS / 2);
  localparam logic [BCNT_W:0] ONE_W    = (BCNT_W+1)'(1);

  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [LNUM_W-1:0] num_q, num_d;
  logic              lp_d;
  logic [BCNT_W:0]   lim;
  logic              wrap;
  logic              locked;

  always_comb begin
    lim    = half_i ? HALF_LIM : FULL_LIM;
    wrap   = ({1'b0, bcnt_q} + ONE_W) >= lim;
    locked = (num_q != '0);
    bcnt_d = bcnt_q;
    num_d  = num_q;
    lp_d   = 1'b0;
    if (fire_i) begin
      bcnt_d = '0;
      num_d  = LNUM_W'(1);
    end else if (en_i && locked) begin
      if (wrap) begin
        bcnt_d = '0;
        lp_d   = 1'b1;
        num_d  = (num_q == LNUM_W'(LINES)) ? LNUM_W'(1) : num_q + LNUM_W'(1);
      end else begin
        bcnt_d = bcnt_q + BCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q       <= '0;
      num_q        <= '0;
      line_pulse_o <= 1'b0;
    end else begin
      bcnt_q       <= bcnt_d;
      num_q        <= num_d;
      line_pulse_o <= lp_d;
    end
  end

  assign line_num_o = num_q;

  // R7
  line_num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    num_q <= LNUM_W'(LINES));

  // R5
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, bcnt_q} < FULL_LIM);

  // R1
  line_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse_o |-> (num_q != '0));

  // R9
  line_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse_o |=> !line_pulse_o);

endmodule

// File: rtl/fsync_correlator.sv
module fsync_correlator #(
  parameter int             WIN       = 64,
  parameter int             THRESH    = 61,
  parameter logic [WIN-1:0] WORD      = fsc_pkg::FSC_DEFAULT_WORD,
  parameter int             HOLDOFF   = 256,
  parameter int             LINE_BITS = 1296,
  parameter int             LINES     = 625
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_i,
  input  logic                       bit_en_i,
  input  logic                       half_rate_i,
  output logic                       frame_pulse_o,
  output logic                       line_pulse_o,
  output logic [$clog2(LINES+1)-1:0] line_num_o
);

  import fsc_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       hit;
  logic       fire;
  rate_e      rate;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];
  assign rate      = rate_e'(half_rate_i);

  fsc_window #(.WIN(WIN), .THRESH(THRESH), .WORD(WORD)) u_window (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en_i  (bit_en_i),
    .bit_i (bit_i),
    .hit_o (hit)
  );

  fsc_frame_det #(.HOLDOFF(HOLDOFF)) u_frame_det (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .en_i          (bit_en_i),
    .hit_i         (hit),
    .fire_o        (fire),
    .frame_pulse_o (frame_pulse_o)
  );

  fsc_line_timer #(.LINE_BITS(LINE_BITS), .LINES(LINES)) u_line_timer (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .en_i         (bit_en_i),
    .fire_i       (fire),
    .half_i       (rate == RATE_HALF),
    .line_pulse_o (line_pulse_o),
    .line_num_o   (line_num_o)
  );

  // R5
  frame_beats_line_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_pulse_o |-> !line_pulse_o);

  // R7
  frame_sets_line_one_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_pulse_o |-> (line_num_o == ($clog2(LINES+1))'(1)));

  // R8
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bit_en_i |=> (!frame_pulse_o && !line_pulse_o && $stable(line_num_o)));

endmodule

// File: tb/fsync_correlator_bench.sv
`timescale 1ns/1ps
module fsync_correlator_bench;

  localparam int          WIN  = 64;
  localparam int          THR  = 61;
  localparam int          HO   = 70;
  localparam int          LB   = 20;
  localparam int          LN   = 5;
  localparam int          NW   = $clog2(LN + 1);
  localparam logic [63:0] WORD = fsc_pkg::FSC_DEFAULT_WORD;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bit_i;
  logic          bit_en_i;
  logic          half_rate_i;
  logic          frame_pulse_o;
  logic          line_pulse_o;
  logic [NW-1:0] line_num_o;

  always #4 clk = ~clk;

  fsync_correlator #(
    .WIN(WIN), .THRESH(THR), .WORD(WORD), .HOLDOFF(HO), .LINE_BITS(LB), .LINES(LN)
  ) u_fsync_correlator (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_i         (bit_i),
    .bit_en_i      (bit_en_i),
    .half_rate_i   (half_rate_i),
    .frame_pulse_o (frame_pulse_o),
    .line_pulse_o  (line_pulse_o),
    .line_num_o    (line_num_o)
  );

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  // Reference state, built from the requirements.
  logic [63:0] m_win  = '0;
  int          m_hold = 0;
  int          m_bcnt = 0;
  int          m_num  = 0;
  bit          m_fp   = 1'b0;
  bit          m_lp   = 1'b0;
  bit          m_half = 1'b0;

  int   fp_cnt  = 0;
  int   lp_cnt  = 0;
  bit   last_fp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic b, input logic en);
    logic [63:0] nw;
    int agree;
    int lim;
    bit fire;
    bit nlp;
    fire = 1'b0;
    nlp  = 1'b0;
    if (en) begin
      nw = {m_win[62:0], b};
      agree = 0;
      for (int i = 0; i < 64; i++) if (nw[i] == WORD[i]) agree++;
      fire  = (agree >= THR) && (m_hold == 0);
      m_win = nw;
    end
    if (fire) m_hold = HO;
    else if (en && m_hold > 0) m_hold--;
    lim = m_half ? LB / 2 : LB;
    if (fire) begin
      m_bcnt = 0;
      m_num  = 1;
    end else if (en && m_num != 0) begin
      if (m_bcnt >= lim - 1) begin
        m_bcnt = 0;
        nlp    = 1'b1;
        m_num  = (m_num == LN) ? 1 : m_num + 1;
      end else begin
        m_bcnt++;
      end
    end
    m_fp = fire;
    m_lp = nlp;
  endtask

  // One clock: compare outputs of the previous edge, then drive the next bit.
  task automatic step(input logic b, input logic en);
    @(negedge clk);
    chk("R2 frame pulse", int'(frame_pulse_o), int'(m_fp));
    chk("R5 line pulse", int'(line_pulse_o), int'(m_lp));
    chk("R7 line number", int'(line_num_o), m_num);
    last_fp = frame_pulse_o;
    if (frame_pulse_o) fp_cnt++;
    if (line_pulse_o) lp_cnt++;
    bit_i    = b;
    bit_en_i = en;
    model_update(b, en);
  endtask

  function automatic logic next_noise();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) step(next_noise(), 1'b1);
  endtask

  task automatic send_word(input int nflip);
    logic [63:0] mask;
    mask = '0;
    if (nflip > 0) mask[5]  = 1'b1;
    if (nflip > 1) mask[21] = 1'b1;
    if (nflip > 2) mask[38] = 1'b1;
    if (nflip > 3) mask[55] = 1'b1;
    for (int i = 63; i >= 0; i--) step(WORD[i] ^ mask[i], 1'b1);
  endtask

  task automatic set_half(input bit h);
    half_rate_i = h;
    m_half      = h;
  endtask

  initial begin
    int f0;
    int l0;
    rst_n = 1'b0;
    bit_i = 1'b0;
    bit_en_i = 1'b0;
    half_rate_i = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    // R1: reset state
    chk("R1 frame after reset", int'(frame_pulse_o), 0);
    chk("R1 line after reset", int'(line_pulse_o), 0);
    chk("R1 number after reset", int'(line_num_o), 0);

    // R1: no line activity before the first frame
    l0 = lp_cnt;
    noise(100);
    step(1'b0, 1'b0);
    chk("R1 no line pulse unlocked", lp_cnt - l0, 0);
    chk("R1 number unlocked", int'(line_num_o), 0);

    // R2: exact word, pulse one cycle after the last bit
    f0 = fp_cnt;
    send_word(0);
    step(next_noise(), 1'b1);
    chk("R2 pulse timing", int'(last_fp), 1);
    chk("R2 one pulse", fp_cnt - f0, 1);
    chk("R7 number at frame", int'(line_num_o), 1);

    // R5 / R7: five full-rate lines after the frame bit
    l0 = lp_cnt;
    noise(99);
    step(1'b0, 1'b0);
    chk("R5 full-rate line count", lp_cnt - l0, 5);
    chk("R7 number wrapped", int'(line_num_o), 1);

    // R6: half rate halves the line
    set_half(1'b1);
    l0 = lp_cnt;
    noise(40);
    step(1'b0, 1'b0);
    chk("R6 half-rate line count", lp_cnt - l0, 4);
    chk("R7 number after half-rate", int'(line_num_o), 5);

    // R8: enable low freezes everything
    f0 = fp_cnt;
    l0 = lp_cnt;
    for (int i = 0; i < 25; i++) step(next_noise(), 1'b0);
    chk("R8 no frame idle", fp_cnt - f0, 0);
    chk("R8 no line idle", lp_cnt - l0, 0);
    chk("R8 number held", int'(line_num_o), 5);
    set_half(1'b0);

    // R3: tolerance of up to three errors, rejection of four
    for (int k = 0; k <= 4; k++) begin
      noise(90);
      f0 = fp_cnt;
      send_word(k);
      step(next_noise(), 1'b1);
      chk($sformatf("R3 errors=%0d", k), fp_cnt - f0, (k <= 3) ? 1 : 0);
    end

    // R4: holdoff boundary, second word ends on bit HO (ignored) or HO+1 (accepted)
    noise(90);
    f0 = fp_cnt;
    send_word(0);
    noise(HO - 64);
    send_word(0);
    step(next_noise(), 1'b1);
    chk("R4 match inside holdoff ignored", fp_cnt - f0, 1);
    noise(90);
    f0 = fp_cnt;
    send_word(0);
    noise(HO - 63);
    send_word(0);
    step(next_noise(), 1'b1);
    chk("R4 match after holdoff accepted", fp_cnt - f0, 2);

    // R5 / R8 / R6: mixed enable gaps and rate change, cycle model only
    for (int i = 0; i < 600; i++) begin
      logic en;
      en = (lfsr[3:0] > 4'd4);
      if (i == 300) set_half(1'b1);
      if (i == 100 || i == 400) begin
        for (int j = 63; j >= 0; j--) begin
          step(WORD[j], 1'b1);
          if (lfsr[1:0] == 2'b00) step(1'b0, 1'b0);
          void'(next_noise());
        end
      end
      step(next_noise(), en);
    end
    step(1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule